// File: doc/BRIEF.md
# Round-Parallel Key Schedule Generator

This block expands a 128-bit cipher key into the round keys of a 24-round add-rotate-xor block cipher. It produces one whole 192-bit round key per clock. After a key is loaded, the current round key is always present on the output. Each advance moves the schedule one round forward.

Four 32-bit key-state words are updated every round. Each word is mixed with its own rotated copy of a round constant and then rotated by a fixed amount. The four round constants come from a ring of four 32-bit registers. Every word in the ring rotates left by one bit as it moves to its neighbour, so the constant for round i arrives already rotated by i. The three further offsets it needs are plain wire permutations, so no barrel shifter and no constant table are required.

A consumer loads a key, reads `rk_o` while `rk_valid_o` is high, and pulses `adv_i` once per round it consumes. The valid flag falls after the 24th advance.

Top module: `arx_rkey_gen`

## Requirements
- R1: A synchronous reset clears all state. In the cycle after reset, `rk_valid_o` is 0, `round_o` is 0 and `rk_o` is all zero.
- R2: A load copies key word j (`key_i[32j+31:32j]`, j = 0..3) into state word Tj. On the next cycle `rk_valid_o` is 1 and `round_o` is 0.
- R3: The round i constant is ROL_i(D[i mod 4]), where D0=0xc3efe9db, D1=0x44626b02, D2=0x79e27c8a and D3=0x78df30ec. State word j uses that constant rotated left by a further j bits.
- R4: One round updates each word as Tj ← ROL_sj(Tj + constant_j mod 2^32), with s0=1, s1=3, s2=6 and s3=11.
- R5: `rk_o` shows the state words after the update for round `round_o`. Word m sits at bits [32m+31:32m], and words 0..5 carry T0, T1, T2, T1, T3, T1.
- R6: An advance while valid increments `round_o` by one. On the next cycle `rk_o` shows the key of that next round.
- R7: The valid flag stays high for exactly 24 advances after a load. After the 24th advance `rk_valid_o` is 0 and `round_o` reads 24.
- R8: An advance while `rk_valid_o` is 0 has no effect: `rk_o`, `round_o` and the valid flag stay unchanged.
- R9: A load in the same cycle as an advance wins. This holds also in the middle of a schedule: the next cycle shows round 0 of the new key.
- R10: With neither load nor advance, `rk_o` and `round_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Take `key_i` and restart at round 0 |
| key_i | input | 128 | Cipher key, word j at bits [32j+31:32j] |
| adv_i | input | 1 | Move to the next round |
| rk_valid_o | output | 1 | `rk_o` carries a round key of the loaded key |
| round_o | output | 5 | Index of the round shown on `rk_o` |
| rk_o | output | 192 | Round key, six 32-bit words |

## Verification
Two functions can collide in one cycle: a reload and an advance. The bench drives `load_i` and `adv_i` together, both on a fresh schedule and after several rounds of an earlier key. It judges the result by requiring round 0 of the new key on the very next cycle, with no trace of the pending step in either the state words or the constant ring. The same bench also tries an advance on the cycle after the 24th round, where the step must be refused while the stored key stays visible and unchanged.

// File: rtl/arx_ks_pkg.sv
package arx_ks_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned KEY_WORDS = 4;
    localparam int unsigned RK_WORDS  = 6;
    localparam int unsigned ROUNDS    = 24;
    localparam int unsigned RND_W     = $clog2(ROUNDS + 1);
    localparam int unsigned KEY_W     = KEY_WORDS * WORD_W;
    localparam int unsigned RK_W      = RK_WORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    // left rotation by an arbitrary amount, reduced modulo the word width
    function automatic word_t rol(input word_t x, input int unsigned s);
        int unsigned m;
        m = s % WORD_W;
        if (m == 0) begin
            return x;
        end
        return (x << m) | (x >> (WORD_W - m));
    endfunction

    // initial contents of ring slot j
    function automatic word_t seed_const(input int unsigned j);
        case (j % 4)
            0:       return 32'hc3efe9db;
            1:       return 32'h44626b02;
            2:       return 32'h79e27c8a;
            default: return 32'h78df30ec;
        endcase
    endfunction

    // fixed output rotation of state word j
    function automatic int unsigned mix_rot(input int unsigned j);
        case (j)
            0:       return 1;
            1:       return 3;
            2:       return 6;
            default: return 11;
        endcase
    endfunction

    // which state word feeds round-key word m: T0 T1 T2 T1 T3 T1
    function automatic int unsigned rk_src(input int unsigned m);
        case (m)
            0:       return 0;
            2:       return 2;
            4:       return 3;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/arx_const_ring.sv
module arx_const_ring
    import arx_ks_pkg::*;
#(
    parameter int unsigned N = KEY_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    output logic [N*WORD_W-1:0] rcon_o
);

    typedef struct packed {
        logic [N-1:0][WORD_W-1:0] c;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (load_i) begin
            for (int j = 0; j < N; j++) begin
                ring_d.c[j] = seed_const(j);
            end
        end else if (step_i) begin
            // each slot takes its upper neighbour, rotated one bit; slot 0 wraps to the top
            for (int j = 0; j < N; j++) begin
                ring_d.c[j] = rol(ring_q.c[(j + 1) % N], 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    // slot 0 already carries the round rotation; further offsets are wiring only
    for (genvar j = 0; j < N; j++) begin : g_tap
        assign rcon_o[j*WORD_W +: WORD_W] = rol(ring_q.c[0], j);
    end

endmodule

// File: rtl/arx_kmix.sv
module arx_kmix
    import arx_ks_pkg::*;
#(
    parameter int unsigned N = KEY_WORDS
) (
    input  logic [N*WORD_W-1:0] state_i,
    input  logic [N*WORD_W-1:0] rcon_i,
    output logic [N*WORD_W-1:0] state_o
);

    for (genvar j = 0; j < N; j++) begin : g_word
        word_t sum;
        assign sum = state_i[j*WORD_W +: WORD_W] + rcon_i[j*WORD_W +: WORD_W];
        assign state_o[j*WORD_W +: WORD_W] = rol(sum, mix_rot(j));
    end

endmodule

// File: rtl/arx_round_track.sv
module arx_round_track
    import arx_ks_pkg::*;
#(
    parameter int unsigned LAST = ROUNDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             adv_i,
    output logic             step_o,
    output logic             valid_o,
    output logic [RND_W-1:0] round_o
);

    typedef struct packed {
        logic             valid;
        logic [RND_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    assign step_o = trk_q.valid && adv_i && !load_i;

    always_comb begin
        trk_d = trk_q;
        if (load_i) begin
            trk_d.valid = 1'b1;
            trk_d.cnt   = '0;
        end else if (step_o) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
            if (trk_q.cnt == RND_W'(LAST - 1)) begin
                trk_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign valid_o = trk_q.valid;
    assign round_o = trk_q.cnt;

endmodule

// File: rtl/arx_rkey_gen.sv
module arx_rkey_gen
    import arx_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             adv_i,
    output logic             rk_valid_o,
    output logic [RND_W-1:0] round_o,
    output logic [RK_W-1:0]  rk_o
);

    typedef struct packed {
        logic [KEY_W-1:0] t;
    } kstate_t;

    kstate_t           ks_d, ks_q;
    logic              step;
    logic [KEY_W-1:0]  rcon;
    logic [KEY_W-1:0]  mixed;

    arx_round_track #(.LAST(ROUNDS)) i_track (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .step_o  (step),
        .valid_o (rk_valid_o),
        .round_o (round_o)
    );

    arx_const_ring #(.N(KEY_WORDS)) i_ring (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .step_i (step),
        .rcon_o (rcon)
    );

    arx_kmix #(.N(KEY_WORDS)) i_mix (
        .state_i (ks_q.t),
        .rcon_i  (rcon),
        .state_o (mixed)
    );

    always_comb begin
        ks_d = ks_q;
        if (load_i) begin
            ks_d.t = key_i;
        end else if (step) begin
            ks_d.t = mixed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ks_q <= '0;
        end else begin
            ks_q <= ks_d;
        end
    end

    // the round key is the freshly mixed state, words spread as T0 T1 T2 T1 T3 T1
    for (genvar m = 0; m < RK_WORDS; m++) begin : g_rk
        assign rk_o[m*WORD_W +: WORD_W] = mixed[rk_src(m)*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/arx_rkey_gen_chk.sv
module arx_rkey_gen_chk
    import arx_ks_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic             adv_i,
    input logic             rk_valid_o,
    input logic [RND_W-1:0] round_o,
    input logic [RK_W-1:0]  rk_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !rk_valid_o && round_o == '0);

    assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> rk_valid_o && round_o == '0);

    assert_round_step_R6: assert property (@(posedge clk) disable iff (rst)
        rk_valid_o && adv_i && !load_i && round_o < RND_W'(ROUNDS - 1)
        |=> rk_valid_o && round_o == RND_W'($past(round_o) + 1'b1));

    assert_round_range_R6: assert property (@(posedge clk) disable iff (rst)
        rk_valid_o |-> round_o < RND_W'(ROUNDS));

    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
        rk_valid_o && adv_i && !load_i && round_o == RND_W'(ROUNDS - 1)
        |=> !rk_valid_o && round_o == RND_W'(ROUNDS));

    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        !rk_valid_o && !load_i |=> !rk_valid_o && $stable(rk_o) && $stable(round_o));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rk_valid_o && !adv_i && !load_i |=> $stable(rk_o) && $stable(round_o));

endmodule

bind arx_rkey_gen arx_rkey_gen_chk i_chk (.*);

// File: tb/test_arx_rkey_gen.sv
module test_arx_rkey_gen;
    import arx_ks_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             load_i;
    logic [KEY_W-1:0] key_i;
    logic             adv_i;
    logic             rk_valid_o;
    logic [RND_W-1:0] round_o;
    logic [RK_W-1:0]  rk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    arx_rkey_gen i_arx_rkey_gen (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .key_i      (key_i),
        .adv_i      (adv_i),
        .rk_valid_o (rk_valid_o),
        .round_o    (round_o),
        .rk_o       (rk_o)
    );

    localparam logic [31:0] D_TAB [4] = '{32'hc3efe9db, 32'h44626b02, 32'h79e27c8a, 32'h78df30ec};
    localparam int          S_TAB [4] = '{1, 3, 6, 11};

    // stimulus vectors: key and number of idle cycles before each advance
    localparam int NVEC = 4;
    localparam logic [127:0] VEC_KEY [NVEC] = '{
        128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f,
        128'h00000000_00000000_00000000_00000000,
        128'hffffffff_ffffffff_ffffffff_ffffffff,
        128'h13579bdf_2468ace0_0badf00d_deadbeef
    };
    localparam int VEC_GAP [NVEC] = '{0, 1, 2, 0};

    function automatic logic [31:0] brol(input logic [31:0] x, input int s);
        int m;
        m = s % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    // round key of round rnd, computed straight from the schedule equations
    function automatic logic [191:0] model_rk(input logic [127:0] key, input int rnd);
        logic [31:0] t [4];
        for (int j = 0; j < 4; j++) t[j] = key[32*j +: 32];
        for (int r = 0; r <= rnd; r++) begin
            for (int j = 0; j < 4; j++) begin
                t[j] = brol(t[j] + brol(D_TAB[r % 4], r + j), S_TAB[j]);
            end
        end
        return {t[1], t[3], t[1], t[2], t[1], t[0]};
    endfunction

    task automatic chk_rk(input string req, input logic [191:0] exp);
        checks++;
        if (rk_o !== exp) begin
            errors++;
            $display("FAIL %s rk_o act %h exp %h", req, rk_o, exp);
        end
    endtask

    task automatic chk_ctl(input string req, input logic v, input int rnd);
        checks++;
        if (rk_valid_o !== v || round_o !== RND_W'(rnd)) begin
            errors++;
            $display("FAIL %s valid/round act %0b/%0d exp %0b/%0d", req, rk_valid_o, round_o, v, rnd);
        end
    endtask

    // inputs are applied at a falling edge; results are read at the next falling edge
    task automatic drive(input logic ld, input logic [127:0] k, input logic adv);
        load_i = ld;
        key_i  = k;
        adv_i  = adv;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [191:0] held;
        logic [127:0] ka;
        logic [127:0] kb;
        rst    = 1'b1;
        load_i = 1'b0;
        adv_i  = 1'b0;
        key_i  = '0;
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk_ctl("R1", 1'b0, 0);
        chk_rk("R1", '0);
        rst = 1'b0;

        // table walk: full schedule of every key with its idle pattern
        for (int v = 0; v < NVEC; v++) begin
            drive(1'b1, VEC_KEY[v], 1'b0);
            chk_ctl("R2", 1'b1, 0);
            chk_rk("R3/R4/R5", model_rk(VEC_KEY[v], 0));
            for (int r = 1; r <= ROUNDS; r++) begin
                for (int g = 0; g < VEC_GAP[v]; g++) begin
                    drive(1'b0, '0, 1'b0);
                    chk_rk("R10", model_rk(VEC_KEY[v], r - 1));
                    chk_ctl("R10", 1'b1, r - 1);
                end
                drive(1'b0, '0, 1'b1);
                if (r < ROUNDS) begin
                    chk_ctl("R6", 1'b1, r);
                    chk_rk("R6", model_rk(VEC_KEY[v], r));
                end else begin
                    chk_ctl("R7", 1'b0, ROUNDS);
                end
            end
        end

        // R8: advance after the schedule is exhausted
        held = rk_o;
        drive(1'b0, '0, 1'b1);
        chk_ctl("R8", 1'b0, ROUNDS);
        chk_rk("R8", held);
        drive(1'b0, '0, 1'b1);
        chk_rk("R8", held);

        // R9: load and advance together on a fresh schedule
        ka = VEC_KEY[0];
        kb = VEC_KEY[3];
        drive(1'b1, ka, 1'b1);
        chk_ctl("R9", 1'b1, 0);
        chk_rk("R9", model_rk(ka, 0));

        // R9: reload with advance in the middle of a schedule
        for (int r = 0; r < 5; r++) drive(1'b0, '0, 1'b1);
        chk_rk("R6", model_rk(ka, 5));
        drive(1'b1, kb, 1'b1);
        chk_ctl("R9", 1'b1, 0);
        chk_rk("R9", model_rk(kb, 0));
        drive(1'b0, '0, 1'b1);
        chk_ctl("R9", 1'b1, 1);
        chk_rk("R9", model_rk(kb, 1));

        // R1: reset in the middle of a schedule
        rst = 1'b1;
        drive(1'b0, '0, 1'b1);
        rst = 1'b0;
        chk_ctl("R1", 1'b0, 0);
        chk_rk("R1", '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule